// File: doc/BRIEF.md
# SDRAM Mode-Register Command Sequencer

This block turns a single bus write into a pair of mode-register-set commands for an external SDRAM organised as two partition pairs (four chip selects). The write carries a 15-bit mode value and one low-power enable bit per pair. The block first sends the command to partitions 0 and 1, and then to partitions 2 and 3. During each command the value appears unchanged on the upper address lines. No further command from the bus is needed.

A pair's chip selects are driven only when two conditions hold. The pair's banks must be enabled on the configuration input, and the pair's enable bit in the write must be set. A stage that selects nothing still uses its time slot, so the sequence length never changes. A write that arrives during a sequence is held. It starts as soon as the running sequence ends.

The block also provides the normal mode readback word. That word reports a fixed burst length and a fixed burst type. It also reports a CAS latency derived from each pair's timing setting. Bus writes to the readback word have no effect.

Top module: `sdram_mrs_seq`

## Requirements
- R1: While reset is held low, `busy` is 0, all `cs_n` bits and `ras_n`/`cas_n`/`we_n` are 1, `ma_hi` is 0, and `rb_data` reads 0x00220022.
- R2: A write (`lp_wr`=1 at a rising edge while `busy`=0) raises `busy` and drives the first stage's command in the cycle right after that edge.
- R3: A command is one clock in which the selected chip selects, `ras_n`, `cas_n` and `we_n` are all 0. The stage for pair 0 (`cs_n[1:0]`) always comes first, and the stage for pair 1 (`cs_n[3:2]`) always comes second.
- R4: During each command cycle, `ma_hi` equals the written 15-bit value. Outside command cycles, `ma_hi` is 0.
- R5: The chip selects of pair p are driven low in its stage only if `bank_en[p]`=1 and `lp_pair_en[p]`=1.
- R6: A stage that selects no chip still takes its cycle, but in that cycle all command lines stay at 1 (NOP).
- R7: Each command is followed by G NOP cycles, where G is `gap_cfg` for values of 2 or more and G is 2 otherwise. `busy` stays high for exactly 2+2G cycles.
- R8: A write that arrives while `busy`=1, up to and including the last gap cycle, is held. Its first command then follows the last gap cycle directly, and `busy` stays high throughout.
- R9: In `rb_data`, bits [2:0] and [18:16] read 010 (burst of four), and bits 3 and 19 read 0 (sequential). All other bits read 0 except the CAS-latency fields. A write on `rb_wr` changes nothing.
- R10: `rb_data[6:4]` and `rb_data[22:20]` hold the pair's 2-bit `pair_timing` code plus 2. The field is updated one clock after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_wr | input | 1 | Write strobe for the low-power mode register |
| lp_value | input | 15 | Mode value placed on the address lines |
| lp_pair_en | input | 2 | Low-power enable bit per partition pair |
| bank_en | input | 2 | Bank-enable setting per pair from the configuration |
| pair_timing | input | 4 | 2-bit timing code per pair (pair 0 in [1:0]) |
| gap_cfg | input | 4 | Requested NOP gap after each command (minimum 2) |
| rb_wr | input | 1 | Write strobe for the readback word (ignored) |
| rb_wdata | input | 32 | Write data for the readback word (ignored) |
| cs_n | output | 4 | Active-low chip selects, one per partition |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| ma_hi | output | 15 | Upper address lines carrying the mode value |
| busy | output | 1 | Sequence in progress |
| rb_data | output | 32 | Mode readback word |

## Verification
Two events can fall in the same cycle. The end of a sequence (its last gap cycle) can coincide with a fresh register write, and that write must then start a new first-stage command on the very next clock without `busy` dropping. The bench provokes this with a directed write placed exactly in the final gap cycle, and also with random writes at other points of a running sequence. It judges the result by predicting, cycle by cycle, the command lines, chip selects, address value and `busy` of both the old and the held sequence. Readback writes are issued in the same cycles as mode-register writes, and the readback word is compared with a value computed from the timing inputs.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_GAP  = 2'd2
  } seq_state_e;

  localparam logic [2:0] BL_FOUR_CODE = 3'b010;
  localparam logic       BT_SEQ_CODE  = 1'b0;
  localparam int unsigned RB_HALF_W   = 16;
  localparam int unsigned MIN_GAP     = 2;

  // CAS latency field derived from a pair's timing code
  function automatic logic [2:0] cl_from_timing(input logic [1:0] tcode);
    return 3'(tcode) + 3'd2;
  endfunction

  // Effective gap length, never shorter than MIN_GAP
  function automatic int unsigned gap_len(input int unsigned req);
    return (req < MIN_GAP) ? MIN_GAP : req;
  endfunction

  // One partition-pair half of the readback word
  function automatic logic [RB_HALF_W-1:0] rb_half(input logic [2:0] cl);
    return {9'd0, cl, BT_SEQ_CODE, BL_FOUR_CODE};
  endfunction

endpackage

// File: rtl/mrs_trigger.sv
module mrs_trigger #(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned MAW   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [MAW-1:0]   wval,
  input  logic [NPAIR-1:0] wen,
  input  logic             busy,
  input  logic             seq_done,
  output logic             start,
  output logic [MAW-1:0]   act_val,
  output logic [NPAIR-1:0] act_en
);

  logic             pend_v;
  logic [MAW-1:0]   pend_val;
  logic [NPAIR-1:0] pend_en;
  logic             nxt_v;
  logic [MAW-1:0]   nxt_val;
  logic [NPAIR-1:0] nxt_en;

  always_comb begin
    nxt_v   = pend_v | wr;
    nxt_val = wr ? wval : pend_val;
    nxt_en  = wr ? wen  : pend_en;
    start   = (!busy && wr) || (seq_done && nxt_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_val <= '0;
      pend_en  <= '0;
      act_val  <= '0;
      act_en   <= '0;
    end else begin
      if (start) begin
        act_val <= nxt_val;
        act_en  <= nxt_en;
        pend_v  <= 1'b0;
      end else if (wr && busy) begin
        pend_v   <= 1'b1;
        pend_val <= wval;
        pend_en  <= wen;
      end
    end
  end

endmodule

// File: rtl/mrs_stage_fsm.sv
module mrs_stage_fsm
  import mrs_pkg::*;
#(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned GAPW  = 4,
  localparam int unsigned SIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [GAPW-1:0] gap_cfg,
  output logic [SIW-1:0]  stage_idx,
  output logic            busy,
  output logic            cmd_fire,
  output logic            seq_done
);

  seq_state_e      state_q;
  logic [GAPW-1:0] cnt_q;
  logic            last_stage;
  logic            gap_end;

  assign last_stage = (stage_idx == SIW'(NPAIR - 1));
  assign gap_end    = (state_q == SQ_GAP) && (cnt_q == '0);
  assign seq_done   = gap_end && last_stage;
  assign cmd_fire   = (state_q == SQ_CMD);
  assign busy       = (state_q != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      stage_idx <= '0;
      cnt_q     <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q   <= SQ_CMD;
            stage_idx <= '0;
          end
        end
        SQ_CMD: begin
          state_q <= SQ_GAP;
          cnt_q   <= GAPW'(gap_len(32'(gap_cfg)) - 1);
        end
        SQ_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!last_stage) begin
            stage_idx <= stage_idx + 1'b1;
            state_q   <= SQ_CMD;
          end else if (start) begin
            stage_idx <= '0;
            state_q   <= SQ_CMD;
          end else begin
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mrs_cmd_drive.sv
module mrs_cmd_drive #(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned MAW   = 15,
  localparam int unsigned SIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic               cmd_fire,
  input  logic [SIW-1:0]     stage_idx,
  input  logic [MAW-1:0]     act_val,
  input  logic [NPAIR-1:0]   act_en,
  input  logic [NPAIR-1:0]   bank_en,
  output logic [2*NPAIR-1:0] cs_n,
  output logic               ras_n,
  output logic               cas_n,
  output logic               we_n,
  output logic [MAW-1:0]     ma_hi
);

  logic [NPAIR-1:0] pair_sel;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair_sel[p]      = cmd_fire && (stage_idx == SIW'(p)) && bank_en[p] && act_en[p];
    assign cs_n[2*p +: 2]   = {2{~pair_sel[p]}};
  end

  assign ras_n = ~|pair_sel;
  assign cas_n = ~|pair_sel;
  assign we_n  = ~|pair_sel;
  assign ma_hi = cmd_fire ? act_val : '0;

endmodule

// File: rtl/mrs_readback.sv
module mrs_readback
  import mrs_pkg::*;
#(
  parameter int unsigned NPAIR = 2,
  localparam int unsigned RBW  = RB_HALF_W * NPAIR
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rb_wr,
  input  logic [RBW-1:0]     rb_wdata,
  input  logic [2*NPAIR-1:0] pair_timing,
  output logic [RBW-1:0]     rb_data
);

  localparam logic [RBW-1:0] WR_MASK = '0;

  logic [RBW-1:0] calc;
  logic [RBW-1:0] rst_val;
  logic [RBW-1:0] nxt;

  for (genvar p = 0; p < NPAIR; p++) begin : g_half
    assign calc[p*RB_HALF_W +: RB_HALF_W]    = rb_half(cl_from_timing(pair_timing[2*p +: 2]));
    assign rst_val[p*RB_HALF_W +: RB_HALF_W] = rb_half(cl_from_timing(2'd0));
  end

  assign nxt = ((rb_wr ? rb_wdata : '0) & WR_MASK) | (calc & ~WR_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) rb_data <= rst_val;
    else        rb_data <= nxt;
  end

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq #(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned MAW   = 15,
  parameter int unsigned GAPW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lp_wr,
  input  logic [MAW-1:0]        lp_value,
  input  logic [NPAIR-1:0]      lp_pair_en,
  input  logic [NPAIR-1:0]      bank_en,
  input  logic [2*NPAIR-1:0]    pair_timing,
  input  logic [GAPW-1:0]       gap_cfg,
  input  logic                  rb_wr,
  input  logic [16*NPAIR-1:0]   rb_wdata,
  output logic [2*NPAIR-1:0]    cs_n,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic [MAW-1:0]        ma_hi,
  output logic                  busy,
  output logic [16*NPAIR-1:0]   rb_data
);

  localparam int unsigned SIW = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  // named internal events, observed by the checker
  logic             seq_start;
  logic             cmd_fire;
  logic             seq_done;
  logic [SIW-1:0]   stage_idx;
  logic [MAW-1:0]   act_val;
  logic [NPAIR-1:0] act_en;

  mrs_trigger #(.NPAIR(NPAIR), .MAW(MAW)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (lp_wr),
    .wval     (lp_value),
    .wen      (lp_pair_en),
    .busy     (busy),
    .seq_done (seq_done),
    .start    (seq_start),
    .act_val  (act_val),
    .act_en   (act_en)
  );

  mrs_stage_fsm #(.NPAIR(NPAIR), .GAPW(GAPW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .gap_cfg   (gap_cfg),
    .stage_idx (stage_idx),
    .busy      (busy),
    .cmd_fire  (cmd_fire),
    .seq_done  (seq_done)
  );

  mrs_cmd_drive #(.NPAIR(NPAIR), .MAW(MAW)) u_drv (
    .cmd_fire  (cmd_fire),
    .stage_idx (stage_idx),
    .act_val   (act_val),
    .act_en    (act_en),
    .bank_en   (bank_en),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ma_hi     (ma_hi)
  );

  mrs_readback #(.NPAIR(NPAIR)) u_rb (
    .clk         (clk),
    .rst_n       (rst_n),
    .rb_wr       (rb_wr),
    .rb_wdata    (rb_wdata),
    .pair_timing (pair_timing),
    .rb_data     (rb_data)
  );

endmodule

// File: rtl/mrs_seq_checker.sv
module mrs_seq_checker
  import mrs_pkg::*;
#(
  parameter int unsigned NPAIR = 2,
  parameter int unsigned MAW   = 15,
  localparam int unsigned SIW  = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lp_wr,
  input logic [NPAIR-1:0]    bank_en,
  input logic [2*NPAIR-1:0]  pair_timing,
  input logic [2*NPAIR-1:0]  cs_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic [MAW-1:0]      ma_hi,
  input logic                busy,
  input logic [16*NPAIR-1:0] rb_data,
  input logic                cmd_fire,
  input logic                seq_done,
  input logic [SIW-1:0]      stage_idx
);

  assert_cmd_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (!ras_n && !cas_n && !we_n));

  assert_one_cycle_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);

  assert_nop_outside_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |-> (ras_n && cas_n && we_n && (cs_n == '1) && (ma_hi == '0)));

  assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wr && !busy) |=> (busy && cmd_fire && (stage_idx == '0)));

  assert_done_then_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (!busy || (cmd_fire && (stage_idx == '0))));

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    assert_gate_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_en[p] |-> (cs_n[2*p +: 2] == 2'b11));

    assert_fixed_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rb_data[16*p +: 4] == {BT_SEQ_CODE, BL_FOUR_CODE});

    assert_cl_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rb_data[16*p + 4 +: 3] == cl_from_timing($past(pair_timing[2*p +: 2]))));
  end

endmodule

bind sdram_mrs_seq mrs_seq_checker #(.NPAIR(NPAIR), .MAW(MAW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lp_wr       (lp_wr),
  .bank_en     (bank_en),
  .pair_timing (pair_timing),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ma_hi       (ma_hi),
  .busy        (busy),
  .rb_data     (rb_data),
  .cmd_fire    (cmd_fire),
  .seq_done    (seq_done),
  .stage_idx   (stage_idx)
);

// File: tb/sdram_mrs_seq_tb.sv
module sdram_mrs_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_wr = 1'b0;
  logic [14:0] lp_value = '0;
  logic [1:0]  lp_pair_en = '0;
  logic [1:0]  bank_en = '0;
  logic [3:0]  pair_timing = '0;
  logic [3:0]  gap_cfg = '0;
  logic        rb_wr = 1'b0;
  logic [31:0] rb_wdata = '0;
  logic [3:0]  cs_n;
  logic        ras_n, cas_n, we_n;
  logic [14:0] ma_hi;
  logic        busy;
  logic [31:0] rb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mrs_seq u_dut (
    .clk(clk), .rst_n(rst_n), .lp_wr(lp_wr), .lp_value(lp_value),
    .lp_pair_en(lp_pair_en), .bank_en(bank_en), .pair_timing(pair_timing),
    .gap_cfg(gap_cfg), .rb_wr(rb_wr), .rb_wdata(rb_wdata), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ma_hi(ma_hi), .busy(busy),
    .rb_data(rb_data)
  );

  function automatic int eff_gap(input logic [3:0] g);
    if (g < 4'd2) return 2;
    return int'(g);
  endfunction

  function automatic logic [31:0] exp_rb(input logic [3:0] tm);
    logic [31:0] r;
    r = 32'h0002_0002;
    r[6:4]   = {1'b0, tm[1:0]} + 3'd2;
    r[22:20] = {1'b0, tm[3:2]} + 3'd2;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle check of one sequence; optionally places a new write at offset mid_t
  task automatic check_seq(input logic [14:0] v, input logic [1:0] e,
                           input int mid_t, input logic [14:0] mv, input logic [1:0] me);
    int g;
    int len;
    g = eff_gap(gap_cfg);
    len = 2 + 2*g;
    for (int t = 0; t < len; t++) begin
      bit is_cmd;
      int s;
      logic [3:0] ecs;
      is_cmd = (t == 0) || (t == 1 + g);
      s = (t == 0) ? 0 : 1;
      ecs = 4'hF;
      if (is_cmd && bank_en[s] && e[s]) ecs[2*s +: 2] = 2'b00;
      check("R3/R5 chip selects", {28'd0, ecs}, {28'd0, cs_n});
      check("R3/R6 command lines", {29'd0, ras_n, cas_n, we_n},
            (ecs != 4'hF) ? 32'd0 : 32'd7);
      check("R4 address value", {17'd0, ma_hi}, is_cmd ? {17'd0, v} : 32'd0);
      check("R7/R8 busy high", {31'd0, busy}, 32'd1);
      lp_wr = (t == mid_t);
      if (t == mid_t) begin
        lp_value   = mv;
        lp_pair_en = me;
      end
      @(negedge clk);
    end
    lp_wr = 1'b0;
    if (mid_t >= 0) begin
      check_seq(mv, me, -1, '0, '0);
    end else begin
      check("R7 busy falls after last gap", {31'd0, busy}, 32'd0);
      check("R6 idle chip selects", {28'd0, cs_n}, 32'hF);
    end
  endtask

  task automatic run_seq(input logic [14:0] v, input logic [1:0] e,
                         input int mid_t, input logic [14:0] mv, input logic [1:0] me);
    lp_wr      = 1'b1;
    lp_value   = v;
    lp_pair_en = e;
    @(negedge clk);
    lp_wr = 1'b0;
    check_seq(v, e, mid_t, mv, me);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    pair_timing = 4'b1011;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy in reset", {31'd0, busy}, 32'd0);
    check("R1 cs in reset", {28'd0, cs_n}, 32'hF);
    check("R1 cmd lines in reset", {29'd0, ras_n, cas_n, we_n}, 32'd7);
    check("R1 ma in reset", {17'd0, ma_hi}, 32'd0);
    check("R1 readback reset value", rb_data, 32'h0022_0022);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cl after reset", rb_data, exp_rb(pair_timing));

    // R2 R3 R4: both pairs, minimum gap
    bank_en = 2'b11; gap_cfg = 4'd0;
    run_seq(15'h2A5A, 2'b11, -1, '0, '0);
    // R5 pair 1 gated by bank enable
    bank_en = 2'b01; gap_cfg = 4'd5;
    run_seq(15'h1234, 2'b11, -1, '0, '0);
    // R5 pair 0 gated by its own enable bit
    bank_en = 2'b11; gap_cfg = 4'd3;
    run_seq(15'h7FFF, 2'b10, -1, '0, '0);
    // R6 nothing selected: slots kept, NOP only
    bank_en = 2'b00; gap_cfg = 4'd2;
    run_seq(15'h0F0F, 2'b11, -1, '0, '0);
    // R8 write mid-sequence is held
    bank_en = 2'b11; gap_cfg = 4'd2;
    run_seq(15'h0101, 2'b11, 3, 15'h6060, 2'b01);
    // R8 write on the final gap cycle coincides with completion; readback write alongside (R9)
    gap_cfg = 4'd4;
    rb_wr = 1'b1; rb_wdata = 32'hFFFF_FFFF;
    run_seq(15'h3C3C, 2'b11, 9, 15'h4242, 2'b10);
    rb_wr = 1'b0;
    check("R9 readback write ignored", rb_data, exp_rb(pair_timing));

    // R9 R10 readback under varied timing codes with writes attempted
    for (int i = 0; i < 8; i++) begin
      pair_timing = 4'($urandom);
      rb_wr = 1'b1;
      rb_wdata = $urandom;
      @(negedge clk);
      rb_wr = 1'b0;
      check("R10/R9 readback fields", rb_data, exp_rb(pair_timing));
    end

    // Random sequences (R2-R8)
    for (int i = 0; i < 24; i++) begin
      logic [14:0] v, mv;
      logic [1:0]  e, me;
      int mid;
      v = 15'($urandom); mv = 15'($urandom);
      e = 2'($urandom);  me = 2'($urandom);
      bank_en = 2'($urandom);
      gap_cfg = 4'($urandom_range(0, 6));
      if ($urandom_range(0, 2) == 0) mid = int'($urandom_range(0, 2 + 2*eff_gap(gap_cfg) - 1));
      else mid = -1;
      run_seq(v, e, mid, mv, me);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule